// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Unit

This block watches the retirement stream of two processors, a main CPU and a coprocessor, and records into a small circular trace buffer only those instructions that count as a change of flow. Each recorded entry is an address together with an information byte. The information byte says whether the address is where the flow left from (source) or where it arrived (destination), and which processor produced it. Branches the decoder can resolve statically, such as unconditional relative branches and non-indexed jumps and calls, are never stored. So the buffer holds only the points a debugger cannot reconstruct from the program image.

Software, or a debug controller, picks the traced processor and the trace mode, then pulses an arm request. While the unit is armed, qualifying events are written one per clock, and the buffer wraps after its last entry. An end-trigger input marks the final state. At that point the unit disarms, and the change of flow that coincides with the trigger is dropped. The buffer is read back through a synchronous read port. A write pointer and a saturating entry count show where the newest entry lies and how many entries are valid.

The main CPU can retire a destination-type instruction and take an interrupt in the same cycle. In that case the destination is stored first and the vector address on the following clock, through a one-entry holding register.

Top module: `cof_trace_unit`

## Requirements
- R1: Main CPU, armed, mode 2'b00, source select 0: a taken conditional branch (class 1 short, 2 long, 3 bit-conditional, 4 loop primitive) writes its source address with information byte 8'h80. The same classes not taken write nothing.
- R2: Main CPU: classes 5 (indexed jump), 6 (indexed subroutine call), 7 (indexed far call), 8 (return from interrupt), 9 (return from subroutine) and 10 (return from far call) write the destination address with information byte 8'h00, whatever the taken flag.
- R3: A main-CPU interrupt (m_irq high) writes the vector address with information byte 8'h00 when the vector kind is 0 or 3. Kind 1 (software interrupt) and kind 2 (background debug) write nothing.
- R4: Main-CPU classes 0, 11 (short unconditional branch), 12 (long unconditional branch), 13 (branch to subroutine), 14 (enter background) and 15 (non-indexed jump, call or far call) never write an entry.
- R5: Coprocessor, source select 1: class 1 taken writes the source address with information byte 8'hC0. Class 2 (indexed jump-and-link) and class 3 (first address of a new thread) write the destination address with information byte 8'h40. All other classes, and class 1 not taken, write nothing. Coprocessor addresses are zero-extended into bits 22:16.
- R6: Information byte: bit 7 is 1 for a source address, bit 6 is 1 for the coprocessor, and bits 5:0 are 0. Events from the processor that is not selected by ctl_src are ignored.
- R7: If a main-CPU destination-class or taken-branch entry and a recordable interrupt arrive in the same cycle, the instruction entry is written at that clock and the vector entry at the next clock. The source issues no event in that next cycle.
- R8: Each write advances wr_ptr by one modulo 64. entry_count rises by one per write and saturates at 64.
- R9: Reset leaves the unit disarmed with wr_ptr and entry_count at 0. arm_req while disarmed arms the unit and clears wr_ptr and entry_count. Nothing is written while disarmed, and arm_req while armed has no effect.
- R10: end_trig while armed disarms the unit at that clock. The event presented in the same cycle, and any held vector entry, are not written.
- R11: While ctl_mode is not 2'b00, no new event is written.
- R12: rd_data presents {information byte, 23-bit address} of entry rd_addr one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mode | input | 2 | Trace mode, 2'b00 = change-of-flow mode |
| ctl_src | input | 1 | Traced processor, 0 = main CPU, 1 = coprocessor |
| arm_req | input | 1 | Arm pulse, clears pointer and count |
| end_trig | input | 1 | Final state reached, disarms |
| m_valid | input | 1 | Main CPU instruction retired this cycle |
| m_cls | input | 4 | Main CPU instruction class code |
| m_taken | input | 1 | Conditional branch taken |
| m_src_addr | input | 23 | Address of the retiring instruction |
| m_dst_addr | input | 23 | Address the flow continues at |
| m_irq | input | 1 | Interrupt vector fetched this cycle |
| m_vec_kind | input | 2 | Vector kind, 1 = software interrupt, 2 = background debug |
| m_vec_addr | input | 23 | Vector address |
| c_valid | input | 1 | Coprocessor instruction retired this cycle |
| c_cls | input | 3 | Coprocessor instruction class code |
| c_taken | input | 1 | Coprocessor conditional branch taken |
| c_src_addr | input | 16 | Coprocessor instruction address |
| c_dst_addr | input | 16 | Coprocessor destination or thread start address |
| rd_addr | input | 6 | Trace buffer read index |
| rd_data | output | 31 | {info byte, address}, one clock latency |
| armed | output | 1 | Unit is armed |
| wr_ptr | output | 6 | Index of the next entry to be written |
| entry_count | output | 7 | Number of valid entries, saturating at 64 |

## Verification
The hardest state to reach is the holding register being full while an end trigger arrives. This needs a destination-class instruction and a recordable interrupt in the same cycle, followed at once by end_trig, so that the deferred vector entry must vanish. The stimulus re-arms the unit, issues that dual event, and pulses end_trig on the very next clock. It also runs the dual event without a trigger to show the vector landing one clock later. A long run of qualifying branches drives the pointer past the wrap and the count into saturation. Every clock is compared against a behavioural queue model, and the buffer contents are then read back through the read port.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  // Main CPU instruction classes
  localparam logic [3:0] MC_NONE   = 4'd0;
  localparam logic [3:0] MC_BCC    = 4'd1;
  localparam logic [3:0] MC_LBCC   = 4'd2;
  localparam logic [3:0] MC_BITBR  = 4'd3;
  localparam logic [3:0] MC_LOOP   = 4'd4;
  localparam logic [3:0] MC_JMPX   = 4'd5;
  localparam logic [3:0] MC_JSRX   = 4'd6;
  localparam logic [3:0] MC_CALLX  = 4'd7;
  localparam logic [3:0] MC_RTI    = 4'd8;
  localparam logic [3:0] MC_RTS    = 4'd9;
  localparam logic [3:0] MC_RTC    = 4'd10;

  // Vector kinds that are excluded from the trace
  localparam logic [1:0] VK_SWI    = 2'd1;
  localparam logic [1:0] VK_BDM    = 2'd2;

  // Coprocessor instruction classes
  localparam logic [2:0] CC_BCC    = 3'd1;
  localparam logic [2:0] CC_JALX   = 3'd2;
  localparam logic [2:0] CC_THREAD = 3'd3;

  localparam logic [1:0] MODE_COF  = 2'b00;

  // Information byte layout
  localparam int INFO_SRC_BIT = 7;
  localparam int INFO_ID_BIT  = 6;

  function automatic logic [7:0] make_info(input logic is_src, input logic is_cop);
    logic [7:0] b;
    b = 8'h00;
    b[INFO_SRC_BIT] = is_src;
    b[INFO_ID_BIT]  = is_cop;
    return b;
  endfunction
endpackage

// File: rtl/cof_main_classify.sv
module cof_main_classify
  import cof_trace_pkg::*;
#(
  parameter int AW = 23
) (
  input  logic          valid,
  input  logic [3:0]    cls,
  input  logic          taken,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          irq,
  input  logic [1:0]    vec_kind,
  input  logic [AW-1:0] vec_addr,
  output logic          ins_hit,
  output logic          ins_is_src,
  output logic [AW-1:0] ins_addr,
  output logic          vec_hit,
  output logic [AW-1:0] vec_out
);
  logic cond_br, dst_type;

  always_comb begin
    cond_br  = (cls == MC_BCC) || (cls == MC_LBCC) || (cls == MC_BITBR) || (cls == MC_LOOP);
    dst_type = (cls >= MC_JMPX) && (cls <= MC_RTC);
    ins_hit    = valid && ((cond_br && taken) || dst_type);
    ins_is_src = cond_br;
    ins_addr   = cond_br ? src_addr : dst_addr;
    vec_hit    = irq && (vec_kind != VK_SWI) && (vec_kind != VK_BDM);
    vec_out    = vec_addr;
  end
endmodule

// File: rtl/cof_cop_classify.sv
module cof_cop_classify
  import cof_trace_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 23
) (
  input  logic          valid,
  input  logic [2:0]    cls,
  input  logic          taken,
  input  logic [CW-1:0] src_addr,
  input  logic [CW-1:0] dst_addr,
  output logic          hit,
  output logic          is_src,
  output logic [AW-1:0] addr
);
  localparam int PAD = AW - CW;
  logic cond_br, dst_type;

  always_comb begin
    cond_br  = (cls == CC_BCC);
    dst_type = (cls == CC_JALX) || (cls == CC_THREAD);
    hit      = valid && ((cond_br && taken) || dst_type);
    is_src   = cond_br;
    addr     = {{PAD{1'b0}}, (cond_br ? src_addr : dst_addr)};
  end
endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl
  import cof_trace_pkg::*;
#(
  parameter int AW    = 23,
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctl_mode,
  input  logic             ctl_src,
  input  logic             arm_req,
  input  logic             end_trig,
  input  logic             m_hit,
  input  logic             m_is_src,
  input  logic [AW-1:0]    m_addr,
  input  logic             v_hit,
  input  logic [AW-1:0]    v_addr,
  input  logic             c_hit,
  input  logic             c_is_src,
  input  logic [AW-1:0]    c_addr,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [AW+7:0]    wdata,
  output logic             armed,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic          hold_v;
  logic [AW-1:0] hold_addr;
  logic          take_hold;
  logic          live;

  always_comb begin
    live      = armed && !end_trig;
    we        = 1'b0;
    take_hold = 1'b0;
    wdata     = '0;
    if (live) begin
      if (hold_v) begin
        we    = 1'b1;
        wdata = {make_info(1'b0, 1'b0), hold_addr};
      end else if (ctl_mode == MODE_COF) begin
        if (ctl_src) begin
          we    = c_hit;
          wdata = {make_info(c_is_src, 1'b1), c_addr};
        end else if (m_hit) begin
          we        = 1'b1;
          wdata     = {make_info(m_is_src, 1'b0), m_addr};
          take_hold = v_hit;
        end else if (v_hit) begin
          we    = 1'b1;
          wdata = {make_info(1'b0, 1'b0), v_addr};
        end
      end
    end
    waddr = wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      wr_ptr <= '0;
      count  <= '0;
      hold_v <= 1'b0;
    end else if (!armed && arm_req) begin
      armed  <= 1'b1;
      wr_ptr <= '0;
      count  <= '0;
      hold_v <= 1'b0;
    end else if (armed && end_trig) begin
      armed  <= 1'b0;
      hold_v <= 1'b0;
    end else begin
      if (we) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (count != FULL) count <= count + 1'b1;
      end
      hold_v <= take_hold;
    end
  end

  always_ff @(posedge clk) begin
    if (take_hold) hold_addr <= v_addr;
  end
endmodule

// File: rtl/cof_trace_ram.sv
module cof_trace_ram #(
  parameter int DW    = 31,
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cof_trace_unit.sv
module cof_trace_unit #(
  parameter int AW    = 23,
  parameter int CW    = 16,
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int DW    = AW + 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctl_mode,
  input  logic             ctl_src,
  input  logic             arm_req,
  input  logic             end_trig,
  input  logic             m_valid,
  input  logic [3:0]       m_cls,
  input  logic             m_taken,
  input  logic [AW-1:0]    m_src_addr,
  input  logic [AW-1:0]    m_dst_addr,
  input  logic             m_irq,
  input  logic [1:0]       m_vec_kind,
  input  logic [AW-1:0]    m_vec_addr,
  input  logic             c_valid,
  input  logic [2:0]       c_cls,
  input  logic             c_taken,
  input  logic [CW-1:0]    c_src_addr,
  input  logic [CW-1:0]    c_dst_addr,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             armed,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] entry_count
);
  logic          mh, ms, vh, ch, cs, we;
  logic [AW-1:0] ma, va, ca;
  logic [PTR_W-1:0] waddr;
  logic [DW-1:0]    wdata;

  cof_main_classify #(.AW(AW)) u_main (
    .valid(m_valid), .cls(m_cls), .taken(m_taken),
    .src_addr(m_src_addr), .dst_addr(m_dst_addr),
    .irq(m_irq), .vec_kind(m_vec_kind), .vec_addr(m_vec_addr),
    .ins_hit(mh), .ins_is_src(ms), .ins_addr(ma),
    .vec_hit(vh), .vec_out(va)
  );

  cof_cop_classify #(.CW(CW), .AW(AW)) u_cop (
    .valid(c_valid), .cls(c_cls), .taken(c_taken),
    .src_addr(c_src_addr), .dst_addr(c_dst_addr),
    .hit(ch), .is_src(cs), .addr(ca)
  );

  cof_trace_ctrl #(.AW(AW), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_mode(ctl_mode), .ctl_src(ctl_src),
    .arm_req(arm_req), .end_trig(end_trig),
    .m_hit(mh), .m_is_src(ms), .m_addr(ma),
    .v_hit(vh), .v_addr(va),
    .c_hit(ch), .c_is_src(cs), .c_addr(ca),
    .we(we), .waddr(waddr), .wdata(wdata),
    .armed(armed), .wr_ptr(wr_ptr), .count(entry_count)
  );

  cof_trace_ram #(.DW(DW), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/cof_trace_checker.sv
module cof_trace_checker #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ctl_mode,
  input logic             ctl_src,
  input logic             arm_req,
  input logic             end_trig,
  input logic             m_valid,
  input logic [3:0]       m_cls,
  input logic             m_irq,
  input logic [1:0]       m_vec_kind,
  input logic             armed,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [CNT_W-1:0] entry_count
);
  logic dual;
  assign dual = armed && !end_trig && ctl_mode == 2'b00 && !ctl_src && m_valid &&
                m_cls >= 4'd5 && m_cls <= 4'd10 && m_irq && m_vec_kind == 2'd0;

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    entry_count <= CNT_W'(DEPTH));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !end_trig |=> (wr_ptr - $past(wr_ptr)) <= PTR_W'(1));

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !armed && arm_req |=> armed && wr_ptr == '0 && entry_count == '0);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !armed && !arm_req |=> !armed && $stable(wr_ptr) && $stable(entry_count));

  assert_end_disarms_R10: assert property (@(posedge clk) disable iff (rst)
    armed && end_trig |=> !armed && $stable(wr_ptr) && $stable(entry_count));

  assert_dual_first_R7: assert property (@(posedge clk) disable iff (rst)
    dual |=> (wr_ptr - $past(wr_ptr)) == PTR_W'(1));
endmodule

bind cof_trace_unit cof_trace_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_mode(ctl_mode), .ctl_src(ctl_src),
  .arm_req(arm_req), .end_trig(end_trig), .m_valid(m_valid), .m_cls(m_cls),
  .m_irq(m_irq), .m_vec_kind(m_vec_kind), .armed(armed), .wr_ptr(wr_ptr),
  .entry_count(entry_count)
);

// File: tb/cof_trace_unit_test.sv
module cof_trace_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ctl_mode = 2'b00;
  logic ctl_src = 1'b0, arm_req = 1'b0, end_trig = 1'b0;
  logic m_valid = 1'b0, m_taken = 1'b0, m_irq = 1'b0;
  logic [3:0] m_cls = '0;
  logic [22:0] m_src_addr = '0, m_dst_addr = '0, m_vec_addr = '0;
  logic [1:0] m_vec_kind = '0;
  logic c_valid = 1'b0, c_taken = 1'b0;
  logic [2:0] c_cls = '0;
  logic [15:0] c_src_addr = '0, c_dst_addr = '0;
  logic [5:0] rd_addr = '0;
  logic [30:0] rd_data;
  logic armed;
  logic [5:0] wr_ptr;
  logic [6:0] entry_count;

  always #5 clk = ~clk;

  cof_trace_unit uut (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  logic [30:0] ref_mem [64];
  bit ref_wr [64];
  int ref_ptr = 0, ref_cnt = 0;
  bit ref_armed = 0, ref_hold = 0;
  logic [22:0] ref_hold_addr;

  task automatic put(input logic [22:0] a, input logic [7:0] info);
    ref_mem[ref_ptr] = {info, a};
    ref_wr[ref_ptr] = 1;
    ref_ptr = (ref_ptr + 1) % 64;
    if (ref_cnt < 64) ref_cnt++;
  endtask

  always @(posedge clk) begin
    bit got, vec_ok;
    if (rst) begin
      ref_armed = 0; ref_ptr = 0; ref_cnt = 0; ref_hold = 0;
    end else if (!ref_armed && arm_req) begin
      ref_armed = 1; ref_ptr = 0; ref_cnt = 0; ref_hold = 0;
    end else if (ref_armed && end_trig) begin
      ref_armed = 0; ref_hold = 0;                       // R10
    end else if (ref_armed) begin
      if (ref_hold) begin
        put(ref_hold_addr, 8'h00); ref_hold = 0;         // R7
      end else if (ctl_mode == 2'b00) begin              // R11
        if (!ctl_src) begin
          got = 0;
          vec_ok = m_irq && m_vec_kind != 2'd1 && m_vec_kind != 2'd2;
          if (m_valid && m_cls >= 1 && m_cls <= 4 && m_taken) begin
            put(m_src_addr, 8'h80); got = 1;
          end else if (m_valid && m_cls >= 5 && m_cls <= 10) begin
            put(m_dst_addr, 8'h00); got = 1;
          end
          if (vec_ok && got) begin ref_hold = 1; ref_hold_addr = m_vec_addr; end
          else if (vec_ok) put(m_vec_addr, 8'h00);
        end else if (c_valid) begin
          if (c_cls == 1 && c_taken) put({7'd0, c_src_addr}, 8'hC0);
          else if (c_cls == 2 || c_cls == 3) put({7'd0, c_dst_addr}, 8'h40);
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the observable state (R8, R9)
  always @(negedge clk) if (!rst && !done) begin
    chk("R9 armed", armed, ref_armed);
    chk("R8 wr_ptr", wr_ptr, ref_ptr);
    chk("R8 entry_count", entry_count, ref_cnt);
  end

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mev(input logic [3:0] cls, input bit tk, input logic [22:0] s, input logic [22:0] d);
    m_valid = 1; m_cls = cls; m_taken = tk; m_src_addr = s; m_dst_addr = d;
    @(negedge clk);
    m_valid = 0; m_taken = 0;
  endtask

  task automatic irq(input logic [1:0] kind, input logic [22:0] v);
    m_irq = 1; m_vec_kind = kind; m_vec_addr = v;
    @(negedge clk);
    m_irq = 0;
  endtask

  task automatic cev(input logic [2:0] cls, input bit tk, input logic [15:0] s, input logic [15:0] d);
    c_valid = 1; c_cls = cls; c_taken = tk; c_src_addr = s; c_dst_addr = d;
    @(negedge clk);
    c_valid = 0; c_taken = 0;
  endtask

  task automatic arm;
    arm_req = 1; @(negedge clk); arm_req = 0;
  endtask

  // R12: read back every entry the model has written
  task automatic readback(input string tag);
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i);
      @(negedge clk);
      if (ref_wr[i]) chk(tag, rd_data, ref_mem[i]);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_wr[i] = 0;
    idle(3);
    rst = 0;
    idle(1);
    // R9 reset state
    chk("R9 reset armed", armed, 0);
    chk("R9 reset count", entry_count, 0);
    mev(4'd1, 1, 23'h11, 23'h0);          // disarmed: no write (R9)
    chk("R9 disarmed ignore", entry_count, 0);
    arm();
    arm();                                 // R9 arm while armed ignored
    // R1 conditional branches
    for (int c = 1; c <= 4; c++) begin
      mev(4'(c), 1, 23'h400000 + 23'(c), 23'h7);
      mev(4'(c), 0, 23'h1000 + 23'(c), 23'h7);
    end
    chk("R1 four taken", entry_count, 4);
    // R2 destination classes
    for (int c = 5; c <= 10; c++) mev(4'(c), c[0], 23'h3, 23'h520000 + 23'(c));
    chk("R2 six dest", entry_count, 10);
    // R4 never recorded
    mev(4'd0, 1, 23'h9, 23'h9);
    for (int c = 11; c <= 15; c++) mev(4'(c), 1, 23'h9, 23'h9);
    chk("R4 none", entry_count, 10);
    // R3 vectors
    for (int k = 0; k < 4; k++) irq(2'(k), 23'h7FFF00 + 23'(k));
    chk("R3 two vectors", entry_count, 12);
    // R7 dual events
    m_irq = 1; m_vec_kind = 0; m_vec_addr = 23'h7FFFF8;
    mev(4'd6, 0, 23'h0, 23'h234567); m_irq = 0;
    idle(1);
    m_irq = 1; m_vec_kind = 3; m_vec_addr = 23'h7FFFF2;
    mev(4'd2, 1, 23'h0ABCDE, 23'h0); m_irq = 0;
    idle(1);
    m_irq = 1; m_vec_kind = 1; m_vec_addr = 23'h7FFFF6;   // excluded vector, no hold
    mev(4'd9, 0, 23'h0, 23'h045678); m_irq = 0;
    chk("R7 entries", entry_count, 17);
    readback("R12 main entries R1 R2 R3 R7");
    // R6 unselected coprocessor ignored
    cev(3'd2, 1, 16'h1111, 16'h2222);
    chk("R6 cop ignored", entry_count, 17);
    ctl_src = 1;
    // R5 coprocessor rules
    for (int c = 0; c < 8; c++) begin
      cev(3'(c), 1, 16'hA000 + 16'(c), 16'hB000 + 16'(c));
      cev(3'(c), 0, 16'hC000 + 16'(c), 16'hD000 + 16'(c));
    end
    mev(4'd5, 1, 23'h1, 23'h2);            // R6 main ignored
    irq(2'd0, 23'h3);
    chk("R5 cop entries", entry_count, 22);
    // R11 other modes
    for (int m = 1; m < 4; m++) begin
      ctl_mode = 2'(m);
      cev(3'd3, 1, 16'h1, 16'h5);
    end
    chk("R11 mode idle", entry_count, 22);
    ctl_mode = 0;
    readback("R12 cop entries R5 R6");
    // R8 wrap and saturation
    ctl_src = 0;
    for (int i = 0; i < 50; i++) mev(4'd3, 1, 23'(i * 3 + 1), 23'h0);
    chk("R8 saturated", entry_count, 64);
    chk("R8 wrapped ptr", wr_ptr, 8);
    readback("R12 wrapped R8");
    // R10 event at trigger dropped
    end_trig = 1; m_valid = 1; m_cls = 4'd8; m_dst_addr = 23'h6;
    @(negedge clk);
    end_trig = 0; m_valid = 0;
    chk("R10 disarmed", armed, 0);
    chk("R10 dropped", wr_ptr, 8);
    mev(4'd1, 1, 23'h5, 23'h5);
    // R9 re-arm clears, then R10 drops held vector
    arm();
    chk("R9 rearm count", entry_count, 0);
    m_irq = 1; m_vec_kind = 0; m_vec_addr = 23'h7FFFEE;
    mev(4'd10, 0, 23'h0, 23'h1357); m_irq = 0;
    end_trig = 1; @(negedge clk); end_trig = 0;
    chk("R10 held dropped", entry_count, 1);
    idle(2);
    readback("R12 final R10");
    finish_run();
  end
endmodule